// File: doc/BRIEF.md
# Dynamic Bus Sizing Cycle Sequencer

This block turns one internal memory access into the beats of an external bus cycle. The access is an address, a size (byte, half-word or word), a read/write flag and a burst request. The bank that address decoding has already chosen supplies three attributes: its port width, its wait-state count and a burst-inhibit flag. If the bank's port width does not allow the access, the block rejects it with an error pulse and starts no bus cycle. Otherwise it asserts a chip select, presents the beat address with big-endian byte lane enables, holds each data beat off by the programmed number of wait states, and reports completion.

A burst is four beats. The address advances by the port width on each beat. On a bank that allows bursts, one address phase is followed by four data beats. On a burst-inhibited bank the same four beats are run as four separate single-beat cycles, and each of them has its own address phase. A new request is taken only while the sequencer is idle.

Top module: `dbs_cycle_seq`

## Requirements
- R1: While reset is asserted and after it is released, `req_ready` is 1, and `bus_cs`, `bus_addr_stb`, `bus_beat`, `bus_done` and `req_err` are 0.
- R2: The port code `bank_port` is 0 for an 8-bit port, 1 for 16-bit and 2 for 32-bit. The size code `req_size` is 0 for a byte, 1 for a half-word and 2 for a word. An 8-bit port accepts a byte at any address and rejects half-words and words.
- R3: A 16-bit port accepts a byte at any address and a half-word whose address bit 0 is 0. It rejects odd half-words and all words.
- R4: A 32-bit port accepts a byte at any address, a half-word whose address bit 0 is 0, and a word whose address bits 1:0 are 0. Every other combination is rejected.
- R5: A rejected request raises `req_err` for exactly the one cycle that follows the sampling edge, and `bus_cs` stays 0. Port code 3, size code 3 and a burst whose size code differs from the port code are always rejected.
- R6: Bit i of `bus_lane_en` enables byte lane i, and lane 0 is the most significant byte. On a 32-bit port a byte at offset k uses lane k, a half-word uses lanes 0-1 or 2-3, and a word uses all four lanes. On a 16-bit port a byte uses lane 0 (even address) or lane 1 (odd address), and a half-word uses lanes 0-1. An 8-bit port uses lane 0. While `bus_cs` is 0, lanes and address are 0.
- R7: The cycle after an accepted request is an address phase (`bus_addr_stb`). Every data beat (`bus_beat`) is preceded by exactly `bank_wait` wait cycles with `bus_cs` high.
- R8: A burst has four beats. The address on beat k is the request address plus k times the port width in bytes.
- R9: On a bank that allows bursts, a burst has one address phase, `bus_burst` is 1 throughout the cycle, and the beats come every `bank_wait`+1 cycles.
- R10: On a burst-inhibited bank, a burst request is still accepted. It is run as four address-phase/wait/beat sequences, and `bus_burst` stays 0.
- R11: `bus_done` is 1 for the single cycle after the last beat. `req_ready` is 1 again in the next cycle. A request presented while the sequencer is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request will be sampled |
| req_addr | input | AW | Internal byte address |
| req_size | input | 2 | Access size code |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | Burst request |
| bank_port | input | 2 | Selected bank port width code |
| bank_wait | input | WSW | Wait states per beat |
| bank_binh | input | 1 | Bank burst-inhibited |
| req_err | output | 1 | Access rejected (one-cycle pulse) |
| bus_cs | output | 1 | Chip select, high for the whole bus cycle |
| bus_we | output | 1 | Write enable, qualified by chip select |
| bus_addr_stb | output | 1 | Address phase strobe |
| bus_addr | output | AW | Beat address |
| bus_lane_en | output | 4 | Byte lane enables, bit 0 = most significant byte |
| bus_burst | output | 1 | Native burst in progress |
| bus_beat | output | 1 | Data beat strobe |
| bus_done | output | 1 | Cycle complete |

## Verification
In a native burst the end of one data beat and the reload of the wait counter for the next beat happen on the same edge. With zero wait states, that edge also advances the beat address. Bursts with zero, one and two wait states check that beats stay exactly `bank_wait`+1 cycles apart and that the address steps by the port width. The bench also presents a new request in the middle of a burst, while the sequencer is busy. That request is judged ignored if the running burst's beat positions, addresses and done cycle all stay as predicted.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

  localparam int LANES = 4;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADDR = 3'd1,
    ST_WAIT = 3'd2,
    ST_DATA = 3'd3,
    ST_DONE = 3'd4
  } seq_state_e;

  // size codes and port codes share values: byte/8-bit, half/16-bit, word/32-bit
  localparam logic [1:0] CODE_B = 2'd0;
  localparam logic [1:0] CODE_H = 2'd1;
  localparam logic [1:0] CODE_W = 2'd2;

endpackage

// File: rtl/dbs_access_check.sv
module dbs_access_check
  import dbs_pkg::*;
(
  input  logic [1:0]       addr_lo,
  input  logic [1:0]       size,
  input  logic [1:0]       port,
  input  logic             burst,
  output logic             legal,
  output logic [LANES-1:0] lanes
);

  logic fit;

  always_comb begin
    fit   = 1'b0;
    lanes = '0;
    unique case (port)
      CODE_B: begin
        if (size == CODE_B) begin
          fit   = 1'b1;
          lanes = 4'b0001;
        end
      end
      CODE_H: begin
        if (size == CODE_B) begin
          fit   = 1'b1;
          lanes = addr_lo[0] ? 4'b0010 : 4'b0001;
        end else if (size == CODE_H && !addr_lo[0]) begin
          fit   = 1'b1;
          lanes = 4'b0011;
        end
      end
      CODE_W: begin
        if (size == CODE_B) begin
          fit   = 1'b1;
          lanes = 4'b0001 << addr_lo;
        end else if (size == CODE_H && !addr_lo[0]) begin
          fit   = 1'b1;
          lanes = addr_lo[1] ? 4'b1100 : 4'b0011;
        end else if (size == CODE_W && addr_lo == 2'b00) begin
          fit   = 1'b1;
          lanes = 4'b1111;
        end
      end
      default: begin
        fit   = 1'b0;
        lanes = '0;
      end
    endcase
    // a burst moves full port-width beats only
    legal = fit && (!burst || size == port);
  end

endmodule

// File: rtl/dbs_wait_ctr.sv
module dbs_wait_ctr #(
  parameter int WSW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [WSW-1:0] load_val,
  input  logic           dec,
  output logic           last
);

  logic [WSW-1:0] cnt_q;
  logic [WSW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                   cnt_d = load_val;
    else if (dec && cnt_q != 0) cnt_d = cnt_q - WSW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign last = (cnt_q == WSW'(1));

  // R7: counter never wraps below zero
  a_r7_cnt_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q == 0) |=> (cnt_q == 0));

  // R7: a decrement removes exactly one wait cycle
  a_r7_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && dec && cnt_q != 0) |=> (cnt_q == $past(cnt_q) - WSW'(1)));

endmodule

// File: rtl/dbs_seq_fsm.sv
module dbs_seq_fsm
  import dbs_pkg::*;
#(
  parameter int AW        = 16,
  parameter int WSW       = 3,
  parameter int BURST_LEN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [AW-1:0]    req_addr,
  input  logic             req_write,
  input  logic             req_burst,
  input  logic [1:0]       bank_port,
  input  logic [WSW-1:0]   bank_wait,
  input  logic             bank_binh,
  input  logic             chk_legal,
  input  logic [LANES-1:0] chk_lanes,
  input  logic             wc_last,
  output logic             wc_load,
  output logic [WSW-1:0]   wc_val,
  output logic             wc_dec,
  output logic             req_ready,
  output logic             req_err,
  output logic             bus_cs,
  output logic             bus_we,
  output logic             bus_addr_stb,
  output logic [AW-1:0]    bus_addr,
  output logic [LANES-1:0] bus_lane_en,
  output logic             bus_burst,
  output logic             bus_beat,
  output logic             bus_done
);

  localparam int BCW = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
  localparam logic [BCW-1:0] BEAT_LAST = BCW'(BURST_LEN - 1);

  seq_state_e       state_q, state_d;
  logic [AW-1:0]    addr_q;
  logic [1:0]       port_q;
  logic [WSW-1:0]   wait_q;
  logic             we_q, burst_q, binh_q, err_q;
  logic [LANES-1:0] lanes_q;
  logic [BCW-1:0]   beat_q;

  logic accept, reject, last_beat, native, step_en;
  logic [AW-1:0] step;

  assign accept    = (state_q == ST_IDLE) && req_valid && chk_legal;
  assign reject    = (state_q == ST_IDLE) && req_valid && !chk_legal;
  assign last_beat = !burst_q || (beat_q == BEAT_LAST);
  assign native    = burst_q && !binh_q;
  assign step      = AW'(1) << port_q;
  assign step_en   = (state_q == ST_DATA) && !last_beat;
  assign wc_val    = wait_q;

  // next-state process
  always_comb begin
    state_d = state_q;
    wc_load = 1'b0;
    wc_dec  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = ST_ADDR;
      ST_ADDR: begin
        if (wait_q == 0) state_d = ST_DATA;
        else begin
          state_d = ST_WAIT;
          wc_load = 1'b1;
        end
      end
      ST_WAIT: begin
        wc_dec = 1'b1;
        if (wc_last) state_d = ST_DATA;
      end
      ST_DATA: begin
        if (last_beat)         state_d = ST_DONE;
        else if (!native)      state_d = ST_ADDR;
        else if (wait_q == 0)  state_d = ST_DATA;
        else begin
          state_d = ST_WAIT;
          wc_load = 1'b1;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= reject;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      port_q  <= '0;
      wait_q  <= '0;
      we_q    <= 1'b0;
      burst_q <= 1'b0;
      binh_q  <= 1'b0;
      lanes_q <= '0;
      beat_q  <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      port_q  <= bank_port;
      wait_q  <= bank_wait;
      we_q    <= req_write;
      burst_q <= req_burst;
      binh_q  <= bank_binh;
      lanes_q <= chk_lanes;
      beat_q  <= '0;
    end else if (step_en) begin
      addr_q  <= addr_q + step;
      beat_q  <= beat_q + BCW'(1);
    end
  end

  // output decode
  assign bus_cs       = (state_q == ST_ADDR) || (state_q == ST_WAIT) || (state_q == ST_DATA);
  assign bus_addr_stb = (state_q == ST_ADDR);
  assign bus_beat     = (state_q == ST_DATA);
  assign bus_done     = (state_q == ST_DONE);
  assign req_ready    = (state_q == ST_IDLE);
  assign req_err      = err_q;
  assign bus_we       = bus_cs && we_q;
  assign bus_burst    = bus_cs && native;
  assign bus_addr     = bus_cs ? addr_q : '0;
  assign bus_lane_en  = bus_cs ? lanes_q : '0;

  // R5: a rejection never opens a bus cycle
  a_r5_err_no_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> !bus_cs);

  // R11: done is a single-cycle pulse followed by ready
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    bus_done |=> (!bus_done && req_ready));

  // R7: a data beat is always preceded by a cycle with chip select high
  a_r7_beat_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    bus_beat |-> $past(bus_cs));

  // R9: a native burst never re-issues an address phase
  a_r9_single_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_beat && bus_burst) |=> !bus_addr_stb);

  // R10: an emulated burst opens a fresh address phase after each non-final beat
  a_r10_readdr: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_beat && burst_q && binh_q && !last_beat) |=> bus_addr_stb);

  // R8: beat address advances by the port width
  a_r8_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_beat && !last_beat) |=> (bus_addr - $past(bus_addr)) == step);

  // R6: an active cycle always drives at least one lane
  a_r6_lane_present: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cs |-> ($countones(bus_lane_en) != 0));

endmodule

// File: rtl/dbs_cycle_seq.sv
module dbs_cycle_seq
  import dbs_pkg::*;
#(
  parameter int AW        = 16,
  parameter int WSW       = 3,
  parameter int BURST_LEN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [AW-1:0]    req_addr,
  input  logic [1:0]       req_size,
  input  logic             req_write,
  input  logic             req_burst,
  input  logic [1:0]       bank_port,
  input  logic [WSW-1:0]   bank_wait,
  input  logic             bank_binh,
  output logic             req_err,
  output logic             bus_cs,
  output logic             bus_we,
  output logic             bus_addr_stb,
  output logic [AW-1:0]    bus_addr,
  output logic [LANES-1:0] bus_lane_en,
  output logic             bus_burst,
  output logic             bus_beat,
  output logic             bus_done
);

  // asynchronous assert, synchronous release
  logic rst_s1_n, rst_s2_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_n <= 1'b0;
      rst_s2_n <= 1'b0;
    end else begin
      rst_s1_n <= 1'b1;
      rst_s2_n <= rst_s1_n;
    end
  end

  logic             chk_legal;
  logic [LANES-1:0] chk_lanes;
  logic             wc_load, wc_dec, wc_last;
  logic [WSW-1:0]   wc_val;

  dbs_access_check u_check (
    .addr_lo (req_addr[1:0]),
    .size    (req_size),
    .port    (bank_port),
    .burst   (req_burst),
    .legal   (chk_legal),
    .lanes   (chk_lanes)
  );

  dbs_wait_ctr #(.WSW(WSW)) u_wait (
    .clk      (clk),
    .rst_n    (rst_s2_n),
    .load     (wc_load),
    .load_val (wc_val),
    .dec      (wc_dec),
    .last     (wc_last)
  );

  dbs_seq_fsm #(.AW(AW), .WSW(WSW), .BURST_LEN(BURST_LEN)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_s2_n),
    .req_valid    (req_valid),
    .req_addr     (req_addr),
    .req_write    (req_write),
    .req_burst    (req_burst),
    .bank_port    (bank_port),
    .bank_wait    (bank_wait),
    .bank_binh    (bank_binh),
    .chk_legal    (chk_legal),
    .chk_lanes    (chk_lanes),
    .wc_last      (wc_last),
    .wc_load      (wc_load),
    .wc_val       (wc_val),
    .wc_dec       (wc_dec),
    .req_ready    (req_ready),
    .req_err      (req_err),
    .bus_cs       (bus_cs),
    .bus_we       (bus_we),
    .bus_addr_stb (bus_addr_stb),
    .bus_addr     (bus_addr),
    .bus_lane_en  (bus_lane_en),
    .bus_burst    (bus_burst),
    .bus_beat     (bus_beat),
    .bus_done     (bus_done)
  );

endmodule

// File: tb/dbs_cycle_seq_tb.sv
`timescale 1ns/1ps
module dbs_cycle_seq_tb;

  localparam int AW  = 16;
  localparam int WSW = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_write, req_burst, bank_binh;
  logic [AW-1:0] req_addr;
  logic [1:0] req_size, bank_port;
  logic [WSW-1:0] bank_wait;
  logic req_ready, req_err, bus_cs, bus_we, bus_addr_stb, bus_burst, bus_beat, bus_done;
  logic [AW-1:0] bus_addr;
  logic [3:0] bus_lane_en;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #4 clk = ~clk;  // 125 MHz

  dbs_cycle_seq #(.AW(AW), .WSW(WSW), .BURST_LEN(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
    .req_burst(req_burst), .bank_port(bank_port), .bank_wait(bank_wait),
    .bank_binh(bank_binh), .req_err(req_err), .bus_cs(bus_cs), .bus_we(bus_we),
    .bus_addr_stb(bus_addr_stb), .bus_addr(bus_addr), .bus_lane_en(bus_lane_en),
    .bus_burst(bus_burst), .bus_beat(bus_beat), .bus_done(bus_done)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  // One access; expected trace derived from R5..R11 timing rules.
  task automatic run_access(input logic [AW-1:0] a, input logic [1:0] sz,
                            input logic [1:0] pt, input int w, input bit bu,
                            input bit bi, input bit wr, input bit exp_ok,
                            input logic [3:0] exp_lanes, input bit poke,
                            input string tag);
    int nb, step, done_c, blk;
    bit native;
    @(negedge clk);
    req_addr = a; req_size = sz; bank_port = pt; bank_wait = WSW'(w);
    req_burst = bu; bank_binh = bi; req_write = wr; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (!exp_ok) begin
      for (int c = 0; c < 4; c++) begin
        chk(req_err == (c == 0), {tag, " R5"}, "req_err", req_err, c == 0);
        chk(bus_cs == 1'b0, {tag, " R5"}, "bus_cs", bus_cs, 0);
        chk(req_ready == 1'b1, {tag, " R5"}, "req_ready", req_ready, 1);
        @(negedge clk);
      end
      return;
    end
    nb     = bu ? 4 : 1;
    native = bu && !bi;
    step   = 1 << pt;
    blk    = native ? (w + 1) : (w + 2);
    done_c = native ? (nb * (w + 1) + 1) : (nb * (w + 2));
    for (int c = 0; c <= done_c + 1; c++) begin
      bit e_as, e_bt, e_cs;
      int k;
      e_cs = (c < done_c);
      if (native) begin
        e_as = (c == 0);
        e_bt = (c > 0) && (c < done_c) && (c % blk == 0);
        k    = c / blk - 1;
      end else begin
        e_as = (c < done_c) && (c % blk == 0);
        e_bt = (c < done_c) && (c % blk == w + 1);
        k    = c / blk;
      end
      chk(bus_cs == e_cs, {tag, " R7"}, $sformatf("bus_cs c=%0d", c), bus_cs, e_cs);
      chk(bus_addr_stb == e_as, {tag, " R7 R9 R10"}, $sformatf("addr_stb c=%0d", c), bus_addr_stb, e_as);
      chk(bus_beat == e_bt, {tag, " R7 R8"}, $sformatf("beat c=%0d", c), bus_beat, e_bt);
      chk(bus_done == (c == done_c), {tag, " R11"}, $sformatf("done c=%0d", c), bus_done, c == done_c);
      chk(bus_burst == (e_cs && native), {tag, " R9 R10"}, $sformatf("burst c=%0d", c), bus_burst, e_cs && native);
      chk(req_err == 1'b0, {tag, " R5"}, "req_err", req_err, 0);
      if (e_bt) begin
        logic [AW-1:0] ea;
        ea = a + AW'(k * step);
        chk(bus_addr == ea, {tag, " R8"}, $sformatf("addr beat %0d", k), bus_addr, ea);
        chk(bus_lane_en == exp_lanes, {tag, " R6"}, "lanes", bus_lane_en, exp_lanes);
        chk(bus_we == wr, {tag, " R7"}, "we", bus_we, wr);
      end
      if (!e_cs) begin
        chk(bus_lane_en == 4'b0 && bus_addr == '0, {tag, " R6"}, "idle lanes/addr", bus_lane_en, 0);
      end
      if (c == done_c + 1)
        chk(req_ready == 1'b1, {tag, " R11"}, "ready after done", req_ready, 1);
      else
        chk(req_ready == 1'b0, {tag, " R11"}, "ready while busy", req_ready, 0);
      if (poke && c == 2) begin
        req_addr = 16'h4000; req_size = 2'd0; req_burst = 1'b0; req_valid = 1'b1;
      end else begin
        req_valid = 1'b0;
      end
      @(negedge clk);
    end
    req_valid = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_size = '0; req_write = 1'b0;
    req_burst = 1'b0; bank_port = '0; bank_wait = '0; bank_binh = 1'b0;
    repeat (3) @(negedge clk);
    chk(req_ready && !bus_cs && !bus_addr_stb && !bus_beat && !bus_done && !req_err,
        "R1", "outputs in reset", {req_ready, bus_cs, bus_beat, bus_done, req_err}, 5'b10000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready && !bus_cs && !bus_addr_stb && !bus_beat && !bus_done && !req_err,
        "R1", "outputs after reset", {req_ready, bus_cs, bus_beat, bus_done, req_err}, 5'b10000);
  endtask

  task automatic t_port8;
    run_access(16'h0003, 2'd0, 2'd0, 0, 0, 0, 0, 1, 4'b0001, 0, "R2");
    run_access(16'h0010, 2'd0, 2'd0, 2, 0, 0, 1, 1, 4'b0001, 0, "R2");
    run_access(16'h0010, 2'd1, 2'd0, 0, 0, 0, 0, 0, 4'b0000, 0, "R2");
    run_access(16'h0010, 2'd2, 2'd0, 0, 0, 0, 0, 0, 4'b0000, 0, "R2");
  endtask

  task automatic t_port16;
    run_access(16'h0005, 2'd0, 2'd1, 1, 0, 0, 0, 1, 4'b0010, 0, "R3");
    run_access(16'h0004, 2'd0, 2'd1, 0, 0, 0, 0, 1, 4'b0001, 0, "R3");
    run_access(16'h0006, 2'd1, 2'd1, 0, 0, 0, 1, 1, 4'b0011, 0, "R3");
    run_access(16'h0007, 2'd1, 2'd1, 0, 0, 0, 0, 0, 4'b0000, 0, "R3");
    run_access(16'h0004, 2'd2, 2'd1, 0, 0, 0, 0, 0, 4'b0000, 0, "R3");
  endtask

  task automatic t_port32;
    run_access(16'h0102, 2'd0, 2'd2, 0, 0, 0, 0, 1, 4'b0100, 0, "R4 R6");
    run_access(16'h0103, 2'd0, 2'd2, 1, 0, 0, 0, 1, 4'b1000, 0, "R4 R6");
    run_access(16'h0102, 2'd1, 2'd2, 0, 0, 0, 0, 1, 4'b1100, 0, "R4 R6");
    run_access(16'h0100, 2'd1, 2'd2, 0, 0, 0, 1, 1, 4'b0011, 0, "R4 R6");
    run_access(16'h0100, 2'd2, 2'd2, 3, 0, 0, 1, 1, 4'b1111, 0, "R4 R7");
    run_access(16'h0102, 2'd2, 2'd2, 0, 0, 0, 0, 0, 4'b0000, 0, "R4");
    run_access(16'h0101, 2'd1, 2'd2, 0, 0, 0, 0, 0, 4'b0000, 0, "R4");
  endtask

  task automatic t_reject_codes;
    run_access(16'h0000, 2'd0, 2'd3, 0, 0, 0, 0, 0, 4'b0000, 0, "R5");
    run_access(16'h0000, 2'd3, 2'd2, 0, 0, 0, 0, 0, 4'b0000, 0, "R5");
    run_access(16'h0000, 2'd0, 2'd2, 0, 1, 0, 0, 0, 4'b0000, 0, "R5 R8");
    run_access(16'h0000, 2'd1, 2'd2, 0, 1, 1, 0, 0, 4'b0000, 0, "R5 R8");
  endtask

  task automatic t_native_burst;
    run_access(16'h0100, 2'd2, 2'd2, 1, 1, 0, 1, 1, 4'b1111, 0, "R8 R9");
    run_access(16'h0022, 2'd1, 2'd1, 0, 1, 0, 0, 1, 4'b0011, 0, "R8 R9");
    run_access(16'h00FF, 2'd0, 2'd0, 2, 1, 0, 0, 1, 4'b0001, 0, "R8 R9");
    run_access(16'hFFF8, 2'd2, 2'd2, 0, 1, 0, 0, 1, 4'b1111, 0, "R8 R9");
  endtask

  task automatic t_emul_burst;
    run_access(16'h0200, 2'd2, 2'd2, 2, 1, 1, 0, 1, 4'b1111, 0, "R10 R8");
    run_access(16'h0300, 2'd1, 2'd1, 0, 1, 1, 1, 1, 4'b0011, 0, "R10 R8");
  endtask

  task automatic t_busy_ignore;
    run_access(16'h0400, 2'd2, 2'd2, 1, 1, 0, 0, 1, 4'b1111, 1, "R11");
    run_access(16'h0500, 2'd0, 2'd2, 2, 0, 0, 0, 1, 4'b0001, 1, "R11");
  endtask

  initial begin
    t_reset();
    t_port8();
    t_port16();
    t_port32();
    t_reject_codes();
    t_native_burst();
    t_emul_burst();
    t_busy_ignore();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule